// File: doc/BRIEF.md
# Per-Destination Linked-List Packet Buffer

This block is the packet store at one input of an eight-port input-buffered switch. Packets of 72 bits arrive one per cycle. Each is written into a shared pool of 32 slots and appended to one of eight queues, one per output port. The queues are chains of slots: each destination has a head register and a tail register, and one next-slot array serves all of them, so any destination can use any free slot.

The block drives one request bit per destination to the switch scheduler. A bit is high while that destination's queue holds a packet. When the scheduler names a destination with a transmit request, the block removes the oldest packet of that queue and returns its slot to the pool. It then streams the packet out through a shift register as two 36-bit halves on consecutive cycles, with a phase flag on each half.

Top module: `dest_queue_buffer`

## Requirements
- R1: After reset, `req_vec` is 0, `full` is 0 and `out_valid` is 0.
- R2: The destination of a packet is `in_pkt[71:69]`. A packet is stored when `in_valid` is high and `full` is low at a rising clock edge.
- R3: The 32 slots are shared by all destinations. `full` is high exactly when 32 packets are stored. A packet offered while `full` is high is discarded and changes no output.
- R4: From the cycle after each edge, `req_vec[d]` is 1 exactly when queue d holds at least one packet.
- R5: Each destination sends its packets in arrival order. Queues of different destinations do not affect each other's order.
- R6: A transmit request that names a destination with an empty queue is ignored and produces no output.
- R7: An accepted request (`tx_req` high at an edge) sends its packet in the next two cycles. The first cycle has `out_valid`=1, `out_phase`=0 and `out_half`=bits 71:36. The second has `out_valid`=1, `out_phase`=1 and `out_half`=bits 35:0.
- R8: A transmit request is ignored while the first half is on the output. A request made while the second half is on the output is accepted, so packets can be sent back to back.
- R9: A dequeue frees its slot at the same edge: `full` drops in the next cycle. A packet offered in the same cycle as that dequeue, while `full` is still high, is refused.
- R10: An enqueue and a dequeue to the same destination in the same cycle keep FIFO order, including when that queue holds only one packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet offered on `in_pkt` |
| in_pkt | input | 72 | Packet; bits 71:69 select the destination |
| full | output | 1 | All 32 slots are in use |
| req_vec | output | 8 | Non-empty flag for each destination queue |
| tx_req | input | 1 | Transmit request from the scheduler |
| tx_dest | input | 3 | Destination whose head packet is to be sent |
| out_valid | output | 1 | `out_half` carries data |
| out_phase | output | 1 | 0 = upper half, 1 = lower half |
| out_half | output | 36 | Packet half toward the crossbar |

## Verification
Some internal faults leave the outputs correct for a while. A broken next-slot link or a stale head shows up at the next dequeue of that destination: the wrong packet halves appear one and two cycles after the request. A free-pool error, such as a slot that leaks or is allocated twice, shows up much later. It appears as `full` rising early, or as data overwritten inside another queue, seen only when that queue drains. For this reason the bench keeps its own model of every queue and compares every output half and every request bit on every cycle. It also fills and drains the buffer many times, so that a lost slot builds up until it is visible.

// File: rtl/dqb_pkg.sv
package dqb_pkg;
  localparam int unsigned DEF_PKT_W = 72;
  localparam int unsigned DEF_PORTS = 8;
  localparam int unsigned DEF_DEPTH = 32;

  typedef enum logic [1:0] {
    SND_IDLE = 2'd0,
    SND_HI   = 2'd1,
    SND_LO   = 2'd2
  } snd_state_t;
endpackage

// File: rtl/free_slot_pool.sv
module free_slot_pool #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             free_en,
  input  logic [PTR_W-1:0] free_idx,
  output logic [PTR_W-1:0] alloc_idx,
  output logic             full
);
  logic [DEPTH-1:0] used;

  // Lowest-numbered slot that is not in use.
  function automatic logic [PTR_W-1:0] lowest_free(input logic [DEPTH-1:0] map);
    logic [PTR_W-1:0] idx;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!map[i]) idx = PTR_W'(i);
    end
    return idx;
  endfunction

  assign alloc_idx = lowest_free(used);
  assign full      = &used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used <= '0;
    end else begin
      if (alloc)   used[alloc_idx] <= 1'b1;
      if (free_en) used[free_idx]  <= 1'b0;
    end
  end

  assert_alloc_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !used[alloc_idx]);
  assert_free_was_used_R9: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> used[free_idx]);
  assert_count_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !free_en) |=> ($countones(used) == $past($countones(used)) + 1));
endmodule

// File: rtl/pkt_store.sv
module pkt_store #(
  parameter int unsigned PKT_W = 72,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [PKT_W-1:0] wr_data,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [PKT_W-1:0] rd_data
);
  logic [PKT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/queue_links.sv
module queue_links #(
  parameter int unsigned PORTS = 8,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned DEST_W = $clog2(PORTS),
  localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq,
  input  logic [DEST_W-1:0] enq_dest,
  input  logic [PTR_W-1:0]  enq_slot,
  input  logic              deq,
  input  logic [DEST_W-1:0] deq_dest,
  output logic [PTR_W-1:0]  deq_slot,
  output logic [PORTS-1:0]  nonempty
);
  logic [PTR_W-1:0] head [PORTS];
  logic [PTR_W-1:0] tail [PORTS];
  logic [PTR_W-1:0] nxt  [DEPTH];
  logic [PORTS-1:0] qv;

  // Named internal events
  logic deq_last;        // dequeue takes the only packet of its queue
  logic enq_fresh;       // enqueue starts a new chain
  logic enq_link;        // enqueue extends an existing chain

  assign deq_slot  = head[deq_dest];
  assign deq_last  = deq && (head[deq_dest] == tail[deq_dest]);
  assign enq_fresh = enq && (!qv[enq_dest] || (deq_last && deq_dest == enq_dest));
  assign enq_link  = enq && !enq_fresh;
  assign nonempty  = qv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qv <= '0;
      for (int p = 0; p < int'(PORTS); p++) begin
        head[p] <= '0;
        tail[p] <= '0;
      end
    end else begin
      if (deq) begin
        if (deq_last) qv[deq_dest] <= 1'b0;
        else          head[deq_dest] <= nxt[head[deq_dest]];
      end
      if (enq_fresh) begin
        head[enq_dest] <= enq_slot;
        tail[enq_dest] <= enq_slot;
        qv[enq_dest]   <= 1'b1;
      end else if (enq_link) begin
        tail[enq_dest] <= enq_slot;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (enq_link) nxt[tail[enq_dest]] <= enq_slot;
  end

  assert_deq_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deq |-> qv[deq_dest]);
  assert_enq_sets_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enq |=> (nonempty[$past(enq_dest)] == 1'b1));
  assert_last_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_last && !(enq && enq_dest == deq_dest)) |=> !nonempty[$past(deq_dest)]);
endmodule

// File: rtl/half_sender.sv
module half_sender
  import dqb_pkg::*;
#(
  parameter int unsigned PKT_W = 72,
  localparam int unsigned HALF_W = PKT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PKT_W-1:0]  load_pkt,
  output logic              can_load,
  output logic              out_valid,
  output logic              out_phase,
  output logic [HALF_W-1:0] out_half
);
  snd_state_t       st;
  logic [PKT_W-1:0] sreg;

  assign can_load  = (st != SND_HI);
  assign out_valid = (st != SND_IDLE);
  assign out_phase = (st == SND_LO);
  assign out_half  = sreg[PKT_W-1 -: HALF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SND_IDLE;
      sreg <= '0;
    end else if (load) begin
      st   <= SND_HI;
      sreg <= load_pkt;
    end else begin
      unique case (st)
        SND_HI:  begin
          st   <= SND_LO;
          sreg <= {sreg[HALF_W-1:0], {HALF_W{1'b0}}};
        end
        SND_LO:  st <= SND_IDLE;
        default: st <= SND_IDLE;
      endcase
    end
  end

  assert_hi_then_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_phase) |=> (out_valid && out_phase));
  assert_no_load_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SND_HI) |-> !load);
endmodule

// File: rtl/dest_queue_buffer.sv
module dest_queue_buffer
  import dqb_pkg::*;
#(
  parameter int unsigned PKT_W = DEF_PKT_W,
  parameter int unsigned PORTS = DEF_PORTS,
  parameter int unsigned DEPTH = DEF_DEPTH,
  localparam int unsigned DEST_W = $clog2(PORTS),
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned HALF_W = PKT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PKT_W-1:0]  in_pkt,
  output logic              full,
  output logic [PORTS-1:0]  req_vec,
  input  logic              tx_req,
  input  logic [DEST_W-1:0] tx_dest,
  output logic              out_valid,
  output logic              out_phase,
  output logic [HALF_W-1:0] out_half
);
  function automatic logic [DEST_W-1:0] dest_of(input logic [PKT_W-1:0] p);
    return p[PKT_W-1 -: DEST_W];
  endfunction

  logic             acc_in, acc_tx, can_load;
  logic [PTR_W-1:0] new_slot, head_slot;
  logic [PKT_W-1:0] head_pkt;
  logic [PORTS-1:0] nonempty;

  assign acc_in  = in_valid && !full;
  assign acc_tx  = tx_req && nonempty[tx_dest] && can_load;
  assign req_vec = nonempty;

  free_slot_pool #(.DEPTH(DEPTH)) u_pool (
    .clk(clk), .rst_n(rst_n), .alloc(acc_in), .free_en(acc_tx),
    .free_idx(head_slot), .alloc_idx(new_slot), .full(full)
  );

  pkt_store #(.PKT_W(PKT_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(acc_in), .wr_idx(new_slot), .wr_data(in_pkt),
    .rd_idx(head_slot), .rd_data(head_pkt)
  );

  queue_links #(.PORTS(PORTS), .DEPTH(DEPTH)) u_links (
    .clk(clk), .rst_n(rst_n), .enq(acc_in), .enq_dest(dest_of(in_pkt)),
    .enq_slot(new_slot), .deq(acc_tx), .deq_dest(tx_dest),
    .deq_slot(head_slot), .nonempty(nonempty)
  );

  half_sender #(.PKT_W(PKT_W)) u_send (
    .clk(clk), .rst_n(rst_n), .load(acc_tx), .load_pkt(head_pkt),
    .can_load(can_load), .out_valid(out_valid), .out_phase(out_phase),
    .out_half(out_half)
  );

  assert_tx_starts_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_tx |=> (out_valid && !out_phase));
  assert_full_refuses_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !acc_tx) |=> full);
endmodule

// File: tb/dest_queue_buffer_bench.sv
module dest_queue_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [71:0] in_pkt = '0;
  logic        full;
  logic [7:0]  req_vec;
  logic        tx_req = 1'b0;
  logic [2:0]  tx_dest = '0;
  logic        out_valid, out_phase;
  logic [35:0] out_half;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [71:0] mq [0:7][0:31];
  int          mcount [0:7];
  int          total = 0;
  logic        s_valid = 0, s_phase = 0;
  logic [71:0] s_pkt = '0;
  int          seq = 0;

  always #5 clk = ~clk;

  dest_queue_buffer u_dest_queue_buffer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pkt(in_pkt),
    .full(full), .req_vec(req_vec), .tx_req(tx_req), .tx_dest(tx_dest),
    .out_valid(out_valid), .out_phase(out_phase), .out_half(out_half)
  );

  task automatic check(input bit ok, input string tag, input logic [71:0] act,
                       input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_req();
    logic [7:0] r;
    for (int d = 0; d < 8; d++) r[d] = (mcount[d] > 0);
    return r;
  endfunction

  function automatic logic [35:0] exp_half();
    return s_phase ? s_pkt[35:0] : s_pkt[71:36];
  endfunction

  function automatic logic [71:0] mk_pkt(input logic [2:0] d);
    seq++;
    return {d, 5'(seq), 32'($urandom), 32'($urandom)};
  endfunction

  task automatic compare(input string tag);
    check(req_vec == exp_req(), {"R4 req_vec ", tag}, 72'(req_vec), 72'(exp_req()));
    check(full == (total == 32), {"R3 full ", tag}, 72'(full), 72'(total == 32));
    check(out_valid == s_valid, {"R7 out_valid ", tag}, 72'(out_valid), 72'(s_valid));
    if (s_valid) begin
      check(out_phase == s_phase, {"R7 out_phase ", tag}, 72'(out_phase), 72'(s_phase));
      check(out_half == exp_half(), {"R5 out_half ", tag}, 72'(out_half), 72'(exp_half()));
    end
  endtask

  // Called at a falling edge; applies inputs for one cycle and checks after it.
  task automatic cycle(input logic iv, input logic [71:0] pk, input logic tr,
                       input logic [2:0] td, input string tag);
    logic acc_i, acc_t;
    int d;
    in_valid = iv; in_pkt = pk; tx_req = tr; tx_dest = td;
    acc_i = iv && (total < 32);
    acc_t = tr && (mcount[td] > 0) && (!s_valid || s_phase);
    @(posedge clk);
    if (acc_t) begin
      s_pkt = mq[td][0];
      for (int k = 0; k < 31; k++) mq[td][k] = mq[td][k+1];
      mcount[td]--;
      s_valid = 1; s_phase = 0;
    end else if (s_valid && !s_phase) s_phase = 1;
    else s_valid = 0;
    if (acc_i) begin
      d = int'(pk[71:69]);
      mq[d][mcount[d]] = pk;
      mcount[d]++;
    end
    total = total + int'(acc_i) - int'(acc_t);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic drain(input string tag);
    for (int n = 0; n < 200 && total > 0; n++) begin
      for (int d = 0; d < 8; d++) begin
        if (mcount[d] > 0) begin
          cycle(0, '0, 1, 3'(d), tag);
          break;
        end
      end
    end
    cycle(0, '0, 0, 0, tag);
    cycle(0, '0, 0, 0, tag);
  endtask

  initial begin
    for (int d = 0; d < 8; d++) mcount[d] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_vec == 8'h00, "R1 req_vec after reset", 72'(req_vec), 72'(0));
    check(full == 1'b0, "R1 full after reset", 72'(full), 72'(0));
    check(out_valid == 1'b0, "R1 out_valid after reset", 72'(out_valid), 72'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R2: destination field selects the queue
    cycle(1, mk_pkt(3'd5), 0, 0, "R2 enqueue dest5");
    check(req_vec == 8'b0010_0000, "R2 req bit 5", 72'(req_vec), 72'(8'b0010_0000));
    cycle(1, mk_pkt(3'd0), 0, 0, "R2 enqueue dest0");
    // R6: request to an empty queue is ignored
    cycle(0, '0, 1, 3'd3, "R6 empty request");
    cycle(0, '0, 0, 0, "R6 idle after");
    check(out_valid == 1'b0, "R6 no output", 72'(out_valid), 72'(0));
    // R7: two-phase send
    cycle(0, '0, 1, 3'd5, "R7 send dest5");
    cycle(0, '0, 0, 0, "R7 second half");
    cycle(0, '0, 0, 0, "R7 done");
    drain("R5 drain1");

    // R10: same-destination enqueue and dequeue with a queue of one
    cycle(1, mk_pkt(3'd2), 0, 0, "R10 setup");
    cycle(1, mk_pkt(3'd2), 1, 3'd2, "R10 enq+deq one");
    cycle(1, mk_pkt(3'd2), 1, 3'd2, "R10 enq during hi");
    cycle(1, mk_pkt(3'd2), 1, 3'd2, "R10 enq+deq lo");
    drain("R10 drain");

    // R8: back-to-back requests
    for (int i = 0; i < 4; i++) cycle(1, mk_pkt(3'd6), 0, 0, "R8 fill");
    for (int i = 0; i < 8; i++) cycle(0, '0, 1, 3'd6, "R8 continuous requests");
    drain("R8 drain");

    // R3/R9: fill to capacity, offer while full, dequeue with a refused offer
    for (int i = 0; i < 34; i++) cycle(1, mk_pkt(3'(i % 3)), 0, 0, "R3 fill");
    check(full == 1'b1, "R3 full at 32", 72'(full), 72'(1));
    cycle(1, mk_pkt(3'd7), 0, 0, "R3 offer while full");
    check(req_vec[7] == 1'b0, "R3 discarded packet", 72'(req_vec[7]), 72'(0));
    cycle(1, mk_pkt(3'd7), 1, 3'd1, "R9 deq with refused offer");
    check(full == 1'b0, "R9 full drops", 72'(full), 72'(0));
    cycle(1, mk_pkt(3'd7), 0, 0, "R9 refill");
    check(full == 1'b1, "R9 full again", 72'(full), 72'(1));
    drain("R9 drain");

    // Random mix in three load levels
    for (int seg = 0; seg < 3; seg++) begin
      int in_rate = (seg == 0) ? 40 : (seg == 1) ? 80 : 60;
      int tx_rate = (seg == 0) ? 70 : (seg == 1) ? 30 : 60;
      for (int n = 0; n < 3000; n++) begin
        logic [2:0] dd = (seg == 1) ? 3'($urandom % 3) : 3'($urandom % 8);
        cycle(($urandom % 100) < in_rate, mk_pkt(dd), ($urandom % 100) < tx_rate,
              3'($urandom % 8), "R5 random");
      end
      drain("R5 random drain");
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule